// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, called side A and side B, through a set of independent byte-wide channel groups (two groups of eight bits by default, sixteen bits in all). Each side of each group keeps a capture register loaded by its own clock. In every direction, a select line chooses whether the driven value comes live from the opposite bus or from the stored copy of it.

Each pin side appears as three separate signals: an input, an output, and a per-bit drive enable. A pad wrapper, or the testbench, resolves these into tri-state pins. Per group, an active-low output enable and a direction bit decide which side, if any, is driven. Capture does not depend on these controls. A rising capture clock always stores the bus it watches, so a group can record traffic while it is isolated or while it drives the other way.

Top module: `regbus_xcvr`

## Requirements
- R1: On a rising edge of `cap_clk_a[g]`, group g's A register loads `a_in[8g+7:8g]`. On a rising edge of `cap_clk_b[g]`, group g's B register loads `b_in[8g+7:8g]`. Each register keeps its value between its own edges.
- R2: Capture happens for every value of `grp_oe_n` and `grp_dir`. This includes the case where the group is driving the side being captured.
- R3: When `grp_oe_n[g]` is 1, `a_drv` and `b_drv` are zero in group g's lanes.
- R4: When `grp_oe_n[g]` is 0 and `grp_dir[g]` is 0, group g's `a_drv` lanes are all ones and its `b_drv` lanes are all zeros.
- R5: When `grp_oe_n[g]` is 0 and `grp_dir[g]` is 1, group g's `b_drv` lanes are all ones and its `a_drv` lanes are all zeros.
- R6: Group g's `a_out` lanes carry `b_in` (live) when `grp_sel_ba[g]` is 0. They carry the stored B register when it is 1. This holds combinationally, whatever the enables are.
- R7: Group g's `b_out` lanes carry `a_in` (live) when `grp_sel_ab[g]` is 0. They carry the stored A register when it is 1. This holds combinationally, whatever the enables are.
- R8: A capture edge that occurs while `rst` is 1 clears that register to zero instead of loading the bus.
- R9: Controls, clocks and data of one group have no effect on any output lane of another group.
- R10: A side's own input never reaches that side's output. With the select on live, changing `a_in` leaves `a_out` unchanged, and changing `b_in` leaves `b_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high clear, applied on capture edges |
| cap_clk_a | input | 2 | Per-group rising-edge clock for the A capture register |
| cap_clk_b | input | 2 | Per-group rising-edge clock for the B capture register |
| grp_oe_n | input | 2 | Per-group active-low output enable |
| grp_dir | input | 2 | Per-group direction: 0 drives side A, 1 drives side B |
| grp_sel_ab | input | 2 | Per-group source for side B: 0 live A, 1 stored A |
| grp_sel_ba | input | 2 | Per-group source for side A: 0 live B, 1 stored B |
| a_in | input | 16 | Value seen on the A-side pins |
| a_out | output | 16 | Value offered to the A-side pins |
| a_drv | output | 16 | Per-bit drive enable for the A-side pins |
| b_in | input | 16 | Value seen on the B-side pins |
| b_out | output | 16 | Value offered to the B-side pins |
| b_drv | output | 16 | Per-bit drive enable for the B-side pins |

## Verification
Drive enables and the live and stored routing paths are combinational. They settle in the same cycle as the stimulus, so the bench checks them one time unit after it changes an input. A register value shows up at the outputs right after the rising capture edge that loads it. The bench raises the capture clock on one falling edge of its pacing clock, lowers it on the next, and only then reads the stored value through the select path. No check is ever sampled on the same edge as a capture, so every result is settled when it is read.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef enum logic { SRC_LIVE = 1'b0, SRC_STORED = 1'b1 } src_sel_e;
  typedef enum logic { SIDE_A = 1'b0, SIDE_B = 1'b1 } side_e;

  // A side is driven when enabled and direction equals that side's code.
  function automatic logic side_driven(input logic oe_n, input logic dir, input side_e side);
    return (!oe_n) && (dir == logic'(side));
  endfunction

  // Pick between the opposite bus and the stored register.
  function automatic logic [7:0] pick_source8(input logic [7:0] live, input logic [7:0] stored,
                                             input src_sel_e sel);
    return (sel == SRC_STORED) ? stored : live;
  endfunction

endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/lane_router.sv
module lane_router #(
  parameter int WIDTH = 8
) (
  input  logic             sel_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);
  import regbus_pkg::*;
  localparam int CHUNKS = (WIDTH + 7) / 8;
  localparam int PADW   = CHUNKS * 8;

  logic [PADW-1:0] live_p, stored_p, y_p;

  always_comb begin
    live_p   = '0;
    stored_p = '0;
    live_p[WIDTH-1:0]   = live;
    stored_p[WIDTH-1:0] = stored;
  end

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    assign y_p[c*8 +: 8] = pick_source8(live_p[c*8 +: 8], stored_p[c*8 +: 8], src_sel_e'(sel_stored));
  end

  assign y = y_p[WIDTH-1:0];

  logic unused_pad;
  assign unused_pad = ^{y_p};
endmodule

// File: rtl/xcvr_group.sv
module xcvr_group #(
  parameter int WIDTH = 8
) (
  input  logic             rst,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out,
  output logic             a_en,
  output logic             b_en,
  output logic [WIDTH-1:0] a_q,
  output logic [WIDTH-1:0] b_q
);
  import regbus_pkg::*;

  capture_reg #(.WIDTH(WIDTH)) u_reg_a (.clk(clk_a), .rst(rst), .d(a_in), .q(a_q));
  capture_reg #(.WIDTH(WIDTH)) u_reg_b (.clk(clk_b), .rst(rst), .d(b_in), .q(b_q));

  // Side B is fed only from A material, side A only from B material.
  lane_router #(.WIDTH(WIDTH)) u_to_b (.sel_stored(sel_ab), .live(a_in), .stored(a_q), .y(b_out));
  lane_router #(.WIDTH(WIDTH)) u_to_a (.sel_stored(sel_ba), .live(b_in), .stored(b_q), .y(a_out));

  assign a_en = side_driven(oe_n, dir, SIDE_A);
  assign b_en = side_driven(oe_n, dir, SIDE_B);
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int GROUPS = 2,
  parameter int LANE_W = 8
) (
  input  logic                     rst,
  input  logic [GROUPS-1:0]        cap_clk_a,
  input  logic [GROUPS-1:0]        cap_clk_b,
  input  logic [GROUPS-1:0]        grp_oe_n,
  input  logic [GROUPS-1:0]        grp_dir,
  input  logic [GROUPS-1:0]        grp_sel_ab,
  input  logic [GROUPS-1:0]        grp_sel_ba,
  input  logic [GROUPS*LANE_W-1:0] a_in,
  output logic [GROUPS*LANE_W-1:0] a_out,
  output logic [GROUPS*LANE_W-1:0] a_drv,
  input  logic [GROUPS*LANE_W-1:0] b_in,
  output logic [GROUPS*LANE_W-1:0] b_out,
  output logic [GROUPS*LANE_W-1:0] b_drv
);
  localparam int TOTAL_W = GROUPS * LANE_W;

  // Named internal state and events for the bound checker.
  logic [TOTAL_W-1:0] a_store_q;
  logic [TOTAL_W-1:0] b_store_q;
  logic [GROUPS-1:0]  a_side_en;
  logic [GROUPS-1:0]  b_side_en;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    xcvr_group #(.WIDTH(LANE_W)) u_grp (
      .rst   (rst),
      .clk_a (cap_clk_a[g]),
      .clk_b (cap_clk_b[g]),
      .oe_n  (grp_oe_n[g]),
      .dir   (grp_dir[g]),
      .sel_ab(grp_sel_ab[g]),
      .sel_ba(grp_sel_ba[g]),
      .a_in  (a_in[g*LANE_W +: LANE_W]),
      .b_in  (b_in[g*LANE_W +: LANE_W]),
      .a_out (a_out[g*LANE_W +: LANE_W]),
      .b_out (b_out[g*LANE_W +: LANE_W]),
      .a_en  (a_side_en[g]),
      .b_en  (b_side_en[g]),
      .a_q   (a_store_q[g*LANE_W +: LANE_W]),
      .b_q   (b_store_q[g*LANE_W +: LANE_W])
    );
    assign a_drv[g*LANE_W +: LANE_W] = {LANE_W{a_side_en[g]}};
    assign b_drv[g*LANE_W +: LANE_W] = {LANE_W{b_side_en[g]}};
  end
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int GROUPS = 2,
  parameter int LANE_W = 8
) (
  input logic                     rst,
  input logic [GROUPS-1:0]        cap_clk_a,
  input logic [GROUPS-1:0]        cap_clk_b,
  input logic [GROUPS-1:0]        grp_oe_n,
  input logic [GROUPS-1:0]        grp_sel_ab,
  input logic [GROUPS-1:0]        grp_sel_ba,
  input logic [GROUPS*LANE_W-1:0] a_in,
  input logic [GROUPS*LANE_W-1:0] b_in,
  input logic [GROUPS*LANE_W-1:0] a_out,
  input logic [GROUPS*LANE_W-1:0] b_out,
  input logic [GROUPS*LANE_W-1:0] a_drv,
  input logic [GROUPS*LANE_W-1:0] b_drv,
  input logic [GROUPS*LANE_W-1:0] a_store_q,
  input logic [GROUPS*LANE_W-1:0] b_store_q
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    assert_capture_a_R1: assert property (@(posedge cap_clk_a[g]) disable iff (rst)
      !rst |=> (a_store_q[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W])));

    assert_capture_b_R1: assert property (@(posedge cap_clk_b[g]) disable iff (rst)
      !rst |=> (b_store_q[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W])));

    assert_isolate_R3: assert property (@(posedge cap_clk_a[g]) disable iff (rst)
      grp_oe_n[g] |-> (a_drv[g*LANE_W +: LANE_W] == '0 && b_drv[g*LANE_W +: LANE_W] == '0));

    // R4 and R5: never both sides of a group driven at once
    assert_one_side_R5: assert property (@(posedge cap_clk_b[g]) disable iff (rst)
      $countones({|a_drv[g*LANE_W +: LANE_W], |b_drv[g*LANE_W +: LANE_W]}) <= 1);

    assert_stored_to_b_R7: assert property (@(posedge cap_clk_a[g]) disable iff (rst)
      grp_sel_ab[g] |-> (b_out[g*LANE_W +: LANE_W] == a_store_q[g*LANE_W +: LANE_W]));

    assert_live_to_a_R6: assert property (@(posedge cap_clk_b[g]) disable iff (rst)
      !grp_sel_ba[g] |-> (a_out[g*LANE_W +: LANE_W] == b_in[g*LANE_W +: LANE_W]));
  end
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.GROUPS(GROUPS), .LANE_W(LANE_W)) u_chk (
  .rst(rst), .cap_clk_a(cap_clk_a), .cap_clk_b(cap_clk_b), .grp_oe_n(grp_oe_n),
  .grp_sel_ab(grp_sel_ab), .grp_sel_ba(grp_sel_ba), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .b_out(b_out), .a_drv(a_drv), .b_drv(b_drv),
  .a_store_q(a_store_q), .b_store_q(b_store_q));

// File: tb/test_regbus_xcvr.sv
module test_regbus_xcvr;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic [1:0]  cap_clk_a, cap_clk_b, grp_oe_n, grp_dir, grp_sel_ab, grp_sel_ba;
  logic [15:0] a_in, a_out, a_drv, b_in, b_out, b_drv;

  regbus_xcvr i_regbus_xcvr (
    .rst(rst), .cap_clk_a(cap_clk_a), .cap_clk_b(cap_clk_b), .grp_oe_n(grp_oe_n),
    .grp_dir(grp_dir), .grp_sel_ab(grp_sel_ab), .grp_sel_ba(grp_sel_ba),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv), .b_in(b_in), .b_out(b_out), .b_drv(b_drv));

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] ea [2];
  logic [7:0] eb [2];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Raise chosen capture clocks on a falling edge, lower them on the next.
  task automatic pulse(input logic [1:0] ma, input logic [1:0] mb);
    @(negedge clk); cap_clk_a = ma; cap_clk_b = mb;
    for (int g = 0; g < 2; g++) begin
      if (ma[g]) ea[g] = rst ? 8'h00 : a_in[g*8 +: 8];
      if (mb[g]) eb[g] = rst ? 8'h00 : b_in[g*8 +: 8];
    end
    @(negedge clk); cap_clk_a = 2'b00; cap_clk_b = 2'b00;
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    a_in = 16'hA5C3; b_in = 16'h3C5A;
    pulse(2'b11, 2'b11);
    rst = 1'b0;
    grp_sel_ab = 2'b11; grp_sel_ba = 2'b11; #1;
    chk("R8 reset A regs", b_out, 16'h0000);
    chk("R8 reset B regs", a_out, 16'h0000);
    chk("R3 reset a_drv", a_drv, 16'h0000);
    chk("R3 reset b_drv", b_drv, 16'h0000);
  endtask

  task automatic t_isolated_capture;
    grp_oe_n = 2'b11; a_in = 16'h1234; b_in = 16'hABCD;
    pulse(2'b11, 2'b11);
    chk("R3 isolated drv", {a_drv[7:0], b_drv[7:0]}, 16'h0000);
    a_in = 16'h0000; b_in = 16'hFFFF; #1;
    chk("R2 stored A while isolated", b_out, 16'h1234);
    chk("R2 stored B while isolated", a_out, 16'hABCD);
  endtask

  task automatic t_modes;
    grp_oe_n[1] = 1'b1;
    a_in = 16'h5566; b_in = 16'h7788;
    for (int m = 0; m < 16; m++) begin
      grp_oe_n[0] = m[3]; grp_dir[0] = m[2]; grp_sel_ab[0] = m[1]; grp_sel_ba[0] = m[0];
      #1;
      chk(m[3] ? "R3 a_drv" : "R4 a_drv", {8'h00, a_drv[7:0]},
          {8'h00, (!m[3] && !m[2]) ? 8'hFF : 8'h00});
      chk(m[3] ? "R3 b_drv" : "R5 b_drv", {8'h00, b_drv[7:0]},
          {8'h00, (!m[3] && m[2]) ? 8'hFF : 8'h00});
      chk("R6 a_out source", {8'h00, a_out[7:0]}, {8'h00, m[0] ? eb[0] : b_in[7:0]});
      chk("R7 b_out source", {8'h00, b_out[7:0]}, {8'h00, m[1] ? ea[0] : a_in[7:0]});
      chk("R9 quiet group 1 drv", {a_drv[15:8], b_drv[15:8]}, 16'h0000);
    end
  endtask

  task automatic t_capture_against_dir;
    grp_oe_n = 2'b00; grp_dir = 2'b00; grp_sel_ab = 2'b11; grp_sel_ba = 2'b00;
    a_in = 16'h9E9E;
    pulse(2'b01, 2'b00);
    chk("R2 A captured while A driven", {8'h00, b_out[7:0]}, {8'h00, 8'h9E});
    grp_dir = 2'b11; b_in = 16'h4242;
    pulse(2'b00, 2'b01);
    chk("R2 B captured while B driven", {8'h00, eb[0]}, {8'h00, 8'h42});
    grp_sel_ba = 2'b11; #1;
    chk("R1 stored B readback", {8'h00, a_out[7:0]}, {8'h00, 8'h42});
    a_in = 16'h0101; #1;
    chk("R1 A register holds", {8'h00, b_out[7:0]}, {8'h00, 8'h9E});
  endtask

  task automatic t_own_side;
    grp_oe_n = 2'b00; grp_dir = 2'b00; grp_sel_ab = 2'b00; grp_sel_ba = 2'b00;
    b_in = 16'h6A6A; a_in = 16'h0000; #1;
    chk("R10 a_out with a_in low", a_out, 16'h6A6A);
    a_in = 16'hFFFF; #1;
    chk("R10 a_out with a_in high", a_out, 16'h6A6A);
    grp_dir = 2'b11; a_in = 16'h3131; b_in = 16'h0000; #1;
    chk("R10 b_out with b_in low", b_out, 16'h3131);
    b_in = 16'hFFFF; #1;
    chk("R10 b_out with b_in high", b_out, 16'h3131);
  endtask

  task automatic t_groups;
    grp_oe_n = 2'b00; grp_dir = 2'b10; grp_sel_ab = 2'b01; grp_sel_ba = 2'b10;
    a_in = 16'hC0DE; b_in = 16'hF00D;
    pulse(2'b01, 2'b01);
    chk("R9 drv split a", a_drv, 16'h00FF);
    chk("R9 drv split b", b_drv, 16'hFF00);
    chk("R9 a_out split", a_out, {eb[1], b_in[7:0]});
    chk("R9 b_out split", b_out, {a_in[15:8], ea[0]});
    grp_sel_ab = 2'b11; grp_sel_ba = 2'b11; #1;
    chk("R9 group1 regs untouched", {b_out[15:8], a_out[15:8]}, {ea[1], eb[1]});
    chk("R1 group0 regs loaded", {b_out[7:0], a_out[7:0]}, {8'hDE, 8'h0D});
  endtask

  task automatic t_reset_again;
    rst = 1'b1;
    pulse(2'b10, 2'b00);
    rst = 1'b0; #1;
    chk("R8 selective clear", b_out, {8'h00, ea[0]});
    chk("R8 other regs kept", a_out, {eb[1], eb[0]});
  endtask

  initial begin
    cap_clk_a = 0; cap_clk_b = 0; grp_oe_n = 2'b11; grp_dir = 0;
    grp_sel_ab = 0; grp_sel_ba = 0; a_in = 0; b_in = 0; rst = 1;
    ea[0] = 0; ea[1] = 0; eb[0] = 0; eb[1] = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_isolated_capture();
    t_modes();
    t_capture_against_dir();
    t_own_side();
    t_groups();
    t_reset_again();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule